// File: doc/BRIEF.md
# Sensor Frame Trigger Sequencer

This block decides when a frame of sensor lines is captured. Software programs it through a small register write port: a command word that arms or aborts a capture and chooses whether to wait for a trigger, a line count, a virtual trigger threshold and a frame-sync delay. Once armed, the sequencer waits for the rising edge of frame sync. If a trigger was requested, it then waits for an edge on the external trigger pin, or for a programmed number of line starts, which acts as a virtual trigger. It then counts line starts until the programmed count is reached. A count of zero means the capture runs until the next frame sync.

A 3-bit state code feeds a status register. Its two low bits give the phase of the sequence. Its top bit is a sticky done flag that only a command write clears. Four single-cycle event outputs, all in the pixel clock domain, feed an interrupt collector: frame sync, external trigger, acquisition over, and a frame-sync event delayed by a programmable number of lines. The trigger pin is asynchronous and passes through a flop synchronizer. Frame sync and line active are already in the pixel clock domain.

Top module: `frame_trig_seq`

## Requirements
- R1: After reset the state code is 3'b000 and all four event outputs are low.
- R2: A write to register 0 with bit 0 set arms the sequencer, and the state code becomes 01 on the next edge. Bit 1 of that write selects trigger mode. On the next frame-sync rising edge the code goes to 10 (waiting for trigger) in trigger mode, or to 11 (transfer until frame over) in free mode.
- R3: While the code is 01, line starts and elapsed time have no effect; only a frame-sync rising edge or a command write moves the state.
- R4: Input trig_rising selects the trigger edge: 1 means a low-to-high pin transition, 0 means high-to-low. The opposite edge leaves the code at 10. The selected edge moves the code from 10 to 11.
- R5: With a nonzero threshold T in register 2, the T-th line start after entering state 10 moves the code to 11 without any pin edge. A threshold of 0 disables the virtual trigger.
- R6: In state 11 with a nonzero line count N in register 1, the N-th line start ends the transfer. On that edge ev_over pulses for exactly one cycle, the low code bits return to 00, and code bit 2 is set.
- R7: With a line count of 0, line starts do not end the transfer. The next frame-sync rising edge ends it, with the same outputs as R6.
- R8: Code bit 2 stays set until the next command write. Any command write clears it, and a command write with bit 0 clear returns the code to 00 from any state.
- R9: ev_fsync pulses for one cycle on the edge that samples each frame-sync rising edge, in every state.
- R10: ev_trig pulses for one cycle on each selected pin edge, in every state. It follows the pin change by three clock edges: two synchronizer stages plus the event register.
- R11: With a delay D in register 3, ev_fsync_dly pulses on the D-th line start after a frame-sync rising edge. With D=0 it pulses together with ev_fsync. A new frame-sync edge restarts a pending delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 line count, 2 virtual threshold, 3 fsync delay |
| wr_data | input | LINE_W | Register write data |
| trig_rising | input | 1 | Trigger edge select: 1 rising, 0 falling |
| frame_sync | input | 1 | Frame sync, active high, pixel clock domain |
| line_act | input | 1 | Line active; a rising edge is one line start |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| state_code | output | 3 | {done, phase[1:0]} |
| ev_fsync | output | 1 | Frame-sync event pulse |
| ev_trig | output | 1 | External trigger event pulse |
| ev_over | output | 1 | Acquisition-over event pulse |
| ev_fsync_dly | output | 1 | Line-delayed frame-sync event pulse |

## Verification
The bench builds the block with LINE_W=6 and SYNC_STAGES=2. The narrow register width keeps every programmed count small, so each line-count end, each virtual threshold and each delay window completes within a few dozen cycles. Two synchronizer stages fix the trigger latency at three edges, and the bench samples ev_trig at exactly that edge for both polarities. The bench also drives the wrong pin edge and confirms the state holds.

// File: rtl/ftrig_pkg.sv
package ftrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WSYNC = 2'b01,
    ST_WTRIG = 2'b10,
    ST_XFER  = 2'b11
  } seq_state_e;

  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_LINES = 2'd1;
  localparam logic [1:0] ADDR_VTHR  = 2'd2;
  localparam logic [1:0] ADDR_DLY   = 2'd3;
endpackage

// File: rtl/ftrig_edge.sv
module ftrig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rising_sel_i,
  output logic edge_o
);
  // sq[0..STAGES-1] is the synchronizer chain, sq[STAGES] the edge history flop
  logic [STAGES:0] sq;

  always_ff @(posedge clk) begin
    if (rst) sq[0] <= 1'b0;
    else     sq[0] <= pin_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) sq[i] <= 1'b0;
      else     sq[i] <= sq[i-1];
    end
  end

  always_comb begin
    if (rising_sel_i) edge_o = sq[STAGES-1] & ~sq[STAGES];
    else              edge_o = ~sq[STAGES-1] & sq[STAGES];
  end

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (!edge_o || !$stable(rising_sel_i))); // R10
endmodule

// File: rtl/ftrig_count.sv
module ftrig_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] target_i,
  output logic         hit_o
);
  logic [W-1:0] count_q;
  logic [W:0]   count_nxt;

  assign count_nxt = {1'b0, count_q} + {{W{1'b0}}, 1'b1};
  assign hit_o     = step_i && !clr_i && (count_nxt == {1'b0, target_i});

  always_ff @(posedge clk) begin
    if (rst || clr_i) count_q <= '0;
    else if (step_i)  count_q <= count_nxt[W-1:0];
  end
endmodule

// File: rtl/frame_trig_seq.sv
module frame_trig_seq
  import ftrig_pkg::*;
#(
  parameter int LINE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              trig_rising,
  input  logic              frame_sync,
  input  logic              line_act,
  input  logic              trig_pin,
  output logic [2:0]        state_code,
  output logic              ev_fsync,
  output logic              ev_trig,
  output logic              ev_over,
  output logic              ev_fsync_dly
);
  localparam logic [LINE_W-1:0] ZERO = '0;

  seq_state_e        state_q;
  logic              done_q;
  logic              need_trig_q;
  logic [LINE_W-1:0] lines_q, vthr_q, dly_q;
  logic              vs_q, hs_q;
  logic              vs_rise, hs_rise;
  logic              cmd_wr;
  logic              trig_edge;
  logic              xfer_hit, virt_hit_raw, dly_hit;
  logic              line_done, trig_go;
  logic              dly_pend_q;

  assign cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
  assign vs_rise = frame_sync & ~vs_q;
  assign hs_rise = line_act & ~hs_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      vthr_q  <= '0;
      dly_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_LINES: lines_q <= wr_data;
        ADDR_VTHR:  vthr_q  <= wr_data;
        ADDR_DLY:   dly_q   <= wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b0;
      hs_q <= 1'b0;
    end else begin
      vs_q <= frame_sync;
      hs_q <= line_act;
    end
  end

  ftrig_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk          (clk),
    .rst          (rst),
    .pin_i        (trig_pin),
    .rising_sel_i (trig_rising),
    .edge_o       (trig_edge)
  );

  ftrig_count #(.W(LINE_W)) i_xfer_cnt (
    .clk (clk), .rst (rst),
    .clr_i (state_q != ST_XFER), .step_i (hs_rise),
    .target_i (lines_q), .hit_o (xfer_hit)
  );

  ftrig_count #(.W(LINE_W)) i_virt_cnt (
    .clk (clk), .rst (rst),
    .clr_i (state_q != ST_WTRIG), .step_i (hs_rise),
    .target_i (vthr_q), .hit_o (virt_hit_raw)
  );

  ftrig_count #(.W(LINE_W)) i_dly_cnt (
    .clk (clk), .rst (rst),
    .clr_i (vs_rise || !dly_pend_q), .step_i (hs_rise),
    .target_i (dly_q), .hit_o (dly_hit)
  );

  assign line_done = (lines_q == ZERO) ? vs_rise : xfer_hit;
  assign trig_go   = trig_edge || (virt_hit_raw && (vthr_q != ZERO));

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      done_q      <= 1'b0;
      need_trig_q <= 1'b0;
      ev_over     <= 1'b0;
    end else begin
      ev_over <= 1'b0;
      if (cmd_wr) begin
        done_q      <= 1'b0;
        need_trig_q <= wr_data[1];
        state_q     <= wr_data[0] ? ST_WSYNC : ST_IDLE;
      end else begin
        case (state_q)
          ST_WSYNC: if (vs_rise) state_q <= need_trig_q ? ST_WTRIG : ST_XFER;
          ST_WTRIG: if (trig_go) state_q <= ST_XFER;
          ST_XFER: if (line_done) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            ev_over <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // event outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_fsync     <= 1'b0;
      ev_trig      <= 1'b0;
      ev_fsync_dly <= 1'b0;
      dly_pend_q   <= 1'b0;
    end else begin
      ev_fsync     <= vs_rise;
      ev_trig      <= trig_edge;
      ev_fsync_dly <= 1'b0;
      if (vs_rise) begin
        ev_fsync_dly <= (dly_q == ZERO);
        dly_pend_q   <= (dly_q != ZERO);
      end else if (dly_pend_q && dly_hit) begin
        ev_fsync_dly <= 1'b1;
        dly_pend_q   <= 1'b0;
      end
    end
  end

  assign state_code = {done_q, state_q};

  AST_WSYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WSYNC && !vs_rise && !cmd_wr) |=> (state_q == ST_WSYNC)); // R3
  AST_OVER_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_over |=> !ev_over); // R6
  AST_OVER_DONE: assert property (@(posedge clk) disable iff (rst)
    ev_over |-> (done_q && state_q == ST_IDLE)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !cmd_wr) |=> done_q); // R8
  AST_FSYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_fsync |=> !ev_fsync); // R9
endmodule

// File: tb/test_frame_trig_seq.sv
`timescale 1ns/1ps
module test_frame_trig_seq;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [LW-1:0] wr_data = '0;
  logic          trig_rising = 1'b1;
  logic          frame_sync = 1'b0;
  logic          line_act = 1'b0;
  logic          trig_pin = 1'b0;
  logic [2:0]    state_code;
  logic          ev_fsync, ev_trig, ev_over, ev_fsync_dly;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_trig_seq #(.LINE_W(LW), .SYNC_STAGES(2)) i_frame_trig_seq (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .trig_rising,
    .frame_sync, .line_act, .trig_pin,
    .state_code, .ev_fsync, .ev_trig, .ev_over, .ev_fsync_dly
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [LW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic vs_pulse();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic hs_pulse();
    @(negedge clk); line_act = 1'b1;
    @(negedge clk); line_act = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 code", state_code, 3'b000);
    chk("R1 events", {ev_fsync, ev_trig, ev_over, ev_fsync_dly}, 4'b0000);
  endtask

  task automatic t_free_count();
    wr(2'd1, 6'd3);
    wr(2'd0, 6'b01);
    chk("R2 armed", state_code, 3'b001);
    repeat (5) @(negedge clk);
    hs_pulse();
    chk("R3 hold in wait-sync", state_code, 3'b001);
    vs_pulse();
    chk("R2 free mode to xfer", state_code, 3'b011);
    chk("R9 fsync pulse", ev_fsync, 1'b1);
    @(negedge clk);
    chk("R9 fsync one cycle", ev_fsync, 1'b0);
    hs_pulse(); hs_pulse();
    chk("R6 not yet over", {ev_over, state_code}, 4'b0011);
    hs_pulse();
    chk("R6 over at third line", {ev_over, state_code}, 4'b1100);
    @(negedge clk);
    chk("R6 over one cycle", ev_over, 1'b0);
    repeat (4) @(negedge clk);
    vs_pulse();
    chk("R8 done sticky", state_code, 3'b100);
    wr(2'd0, 6'b00);
    chk("R8 command clears done", state_code, 3'b000);
  endtask

  task automatic t_trigger();
    trig_rising = 1'b1;
    @(negedge clk); trig_pin = 1'b1;
    repeat (5) @(negedge clk);
    wr(2'd1, 6'd1);
    wr(2'd0, 6'b11);
    vs_pulse();
    chk("R2 trigger mode wait", state_code, 3'b010);
    @(negedge clk); trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 wrong edge ignored", {ev_trig, state_code}, 4'b0010);
    trig_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 rising edge event", ev_trig, 1'b1);
    chk("R4 rising edge starts xfer", state_code, 3'b011);
    @(negedge clk);
    chk("R10 trig one cycle", ev_trig, 1'b0);
    hs_pulse();
    chk("R6 single line xfer", {ev_over, state_code}, 4'b1100);
    trig_rising = 1'b0;
    wr(2'd0, 6'b11);
    vs_pulse();
    chk("R8 rearm clears done", state_code, 3'b010);
    @(negedge clk); trig_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 falling edge starts xfer", {ev_trig, state_code}, 4'b1011);
    wr(2'd0, 6'b00);
    chk("R8 abort to idle", state_code, 3'b000);
    trig_rising = 1'b1;
  endtask

  task automatic t_virtual();
    wr(2'd2, 6'd2);
    wr(2'd0, 6'b11);
    vs_pulse();
    hs_pulse();
    chk("R5 below threshold", state_code, 3'b010);
    hs_pulse();
    chk("R5 virtual trigger", state_code, 3'b011);
    wr(2'd2, 6'd0);
    wr(2'd0, 6'b11);
    vs_pulse();
    hs_pulse(); hs_pulse(); hs_pulse();
    chk("R5 zero threshold disabled", state_code, 3'b010);
    wr(2'd0, 6'b00);
  endtask

  task automatic t_zero_lines();
    wr(2'd1, 6'd0);
    wr(2'd0, 6'b01);
    vs_pulse();
    hs_pulse(); hs_pulse(); hs_pulse();
    chk("R7 lines ignored", {ev_over, state_code}, 4'b0011);
    vs_pulse();
    chk("R7 ends on next fsync", {ev_over, state_code}, 4'b1100);
  endtask

  task automatic t_delay();
    wr(2'd3, 6'd2);
    vs_pulse();
    chk("R11 not at fsync", {ev_fsync, ev_fsync_dly}, 2'b10);
    hs_pulse();
    chk("R11 not after one line", ev_fsync_dly, 1'b0);
    hs_pulse();
    chk("R11 after two lines", ev_fsync_dly, 1'b1);
    wr(2'd3, 6'd0);
    vs_pulse();
    chk("R11 zero delay", {ev_fsync, ev_fsync_dly}, 2'b11);
    wr(2'd3, 6'd2);
    vs_pulse();
    hs_pulse();
    vs_pulse();
    hs_pulse();
    chk("R11 restart on fsync", ev_fsync_dly, 1'b0);
    hs_pulse();
    chk("R11 restarted window", ev_fsync_dly, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_free_count();
    t_trigger();
    t_virtual();
    t_zero_lines();
    t_delay();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule